// File: doc/BRIEF.md
# Two-Port GPIO Register Block with Device Pin Decode

This block is a small memory-mapped GPIO controller holding two ports, A and D. Each port has three registers: a driven-value register, a read-only input view and an output-enable mask. They sit on a 32-bit word bus, and one bus request is issued per cycle. Reading a port's input view returns what the port itself drives, masked by its output enables, with status lines from attached devices merged in on fixed bits.

Writes to the port A driven-value register also steer the control strobes of an attached NAND flash. Software uses one bit of port D as a serial clock. A write to the port D driven-value register that flips that bit raises a one-cycle event toward an attached serial sensor. The event carries the new clock level and a data bit. Reads return their data one cycle after the request.

Top module: `gpio_pin_regs`

## Requirements
- R1: After synchronous reset every register reads as zero, no clock event is pending and all flash strobes are low.
- R2: A word write inside the window stores the data in every word except the two input views, and a later read of that word returns the stored value. Port A driven value is word 0x00, port A enable is word 0x02, port D driven value is word 0x10 and port D enable is word 0x12 (byte address = word * 4).
- R3: A read of word 0x01 returns (A driven AND A enable) OR (flash_ready shifted to bit 7).
- R4: A read of word 0x11 returns (D driven AND D enable) OR (sensor_miso shifted to bit 4).
- R5: The flash strobes follow the stored port A driven value: flash_ale is bit 6, flash_cle is bit 5 and flash_ce is bit 4. They change in the cycle after the write.
- R6: An accepted write to port D driven value raises sclk_evt only when written bit 1 differs from the bit 1 stored before the write. No other write raises it.
- R7: sclk_evt is high for exactly the one cycle after the triggering write. In that cycle sclk_rise equals the new bit 1 and sclk_dat equals written bit 4.
- R8: Writes to the input-view words 0x01 and 0x11 leave all state unchanged.
- R9: Requests at byte address 0x5C or above are outside the window. Such reads return zero and such writes change nothing.
- R10: Only accesses with bus_size = 2 (4 bytes) are accepted. Any other size reads zero and writes nothing.
- R11: Every read request gives bus_rvalid high, with its data, in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address, low two bits ignored |
| bus_size | input | 2 | Access size code, 2 = 4 bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after request |
| bus_rvalid | output | 1 | Read data valid |
| flash_ready | input | 1 | Flash ready/busy status |
| sensor_miso | input | 1 | Serial sensor data-out line |
| flash_ale | output | 1 | Flash address-latch enable |
| flash_cle | output | 1 | Flash command-latch enable |
| flash_ce | output | 1 | Flash chip enable |
| sclk_evt | output | 1 | Serial clock edge event pulse |
| sclk_rise | output | 1 | Edge direction, 1 = rising |
| sclk_dat | output | 1 | Serial data bit carried by the event |

## Verification
A serial clock event and a merged port D input read can land in the same cycle. This happens when the sensor answers an edge by changing its data line while software reads port D back at once. The bench writes a toggling port D value, changes sensor_miso in the cycle the event is visible and issues a read of word 0x11 in that same cycle. It then checks that the read merges the new driven value with the sensor bit. Back-to-back toggling writes are also issued to confirm that each edge is judged against the value stored by the write just before it.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 7;
    localparam int WIN_BYTES = 92;
    localparam int NWORDS    = WIN_BYTES / 4;
    localparam int IDX_W     = ADDR_W - 2;

    // word indices whose roles are fixed
    localparam int A_OUT = 0;
    localparam int A_IN  = 1;
    localparam int A_OE  = 2;
    localparam int D_OUT = 16;
    localparam int D_IN  = 17;
    localparam int D_OE  = 18;

    // bit positions with a fixed meaning
    localparam int RDY_BIT  = 7;
    localparam int ALE_BIT  = 6;
    localparam int CLE_BIT  = 5;
    localparam int CE_BIT   = 4;
    localparam int SCLK_BIT = 1;
    localparam int SDAT_BIT = 4;
    localparam int MISO_BIT = 4;

    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef struct packed {
        logic pulse;
        logic rise;
        logic dat;
    } sclk_evt_t;

    function automatic logic is_din(int i);
        return (i == A_IN) || (i == D_IN);
    endfunction

    function automatic logic access_ok(logic [ADDR_W-1:0] a, logic [1:0] sz);
        return (sz == SZ_WORD) && (int'(a) < WIN_BYTES);
    endfunction
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NWORDS-1:0]             we,
    input  logic [DATA_W-1:0]             wdata,
    output logic [NWORDS-1:0][DATA_W-1:0] regs
);
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        if (is_din(w)) begin : g_view
            assign regs[w] = '0;
        end else begin : g_store
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)        q <= '0;
                else if (we[w]) q <= wdata;
            end
            assign regs[w] = q;

            a_r2_store: assert property (@(posedge clk) disable iff (rst)
                we[w] |=> regs[w] == $past(wdata));
            a_r8_hold: assert property (@(posedge clk) disable iff (rst)
                !we[w] |=> $stable(regs[w]));
        end
    end
endmodule

// File: rtl/gpio_sclk_edge.sv
module gpio_sclk_edge
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_dout,
    input  logic              prev_sclk,
    input  logic [DATA_W-1:0] wdata,
    output sclk_evt_t         evt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            evt <= '0;
        end else begin
            evt.pulse <= wr_dout && (wdata[SCLK_BIT] != prev_sclk);
            if (wr_dout) begin
                evt.rise <= wdata[SCLK_BIT];
                evt.dat  <= wdata[SDAT_BIT];
            end
        end
    end

    a_r7_pulse_src: assert property (@(posedge clk) disable iff (rst)
        evt.pulse |-> $past(wr_dout));
    a_r6_same_level: assert property (@(posedge clk) disable iff (rst)
        (wr_dout && wdata[SCLK_BIT] == prev_sclk) |=> !evt.pulse);
endmodule

// File: rtl/gpio_readmux.sv
module gpio_readmux
    import gpio_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          rd_req,
    input  logic                          ok,
    input  logic [IDX_W-1:0]              idx,
    input  logic [NWORDS-1:0][DATA_W-1:0] regs,
    input  logic                          flash_ready,
    input  logic                          sensor_miso,
    output logic [DATA_W-1:0]             rdata,
    output logic                          rvalid
);
    logic [DATA_W-1:0] a_view, d_view, sel;

    always_comb begin
        a_view = regs[A_OUT] & regs[A_OE];
        a_view[RDY_BIT] = a_view[RDY_BIT] | flash_ready;
        d_view = regs[D_OUT] & regs[D_OE];
        d_view[MISO_BIT] = d_view[MISO_BIT] | sensor_miso;
        if (!ok)                        sel = '0;
        else if (int'(idx) == A_IN)     sel = a_view;
        else if (int'(idx) == D_IN)     sel = d_view;
        else                            sel = regs[idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_req;
            if (rd_req) rdata <= sel;
        end
    end

    a_r11_rvalid: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rvalid);
    a_r9_oob_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !ok) |=> rdata == '0);
    a_r3_ready_bit: assert property (@(posedge clk) disable iff (rst)
        (rd_req && ok && int'(idx) == A_IN && flash_ready) |=> rdata[RDY_BIT]);
    a_r4_miso_bit: assert property (@(posedge clk) disable iff (rst)
        (rd_req && ok && int'(idx) == D_IN && sensor_miso) |=> rdata[MISO_BIT]);
endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic              flash_ready,
    input  logic              sensor_miso,
    output logic              flash_ale,
    output logic              flash_cle,
    output logic              flash_ce,
    output logic              sclk_evt,
    output logic              sclk_rise,
    output logic              sclk_dat
);
    logic                          ok;
    logic                          wr_ok;
    logic [IDX_W-1:0]              idx;
    logic [NWORDS-1:0]             we;
    logic [NWORDS-1:0][DATA_W-1:0] regs;
    sclk_evt_t                     evt;

    assign ok    = bus_valid && access_ok(bus_addr, bus_size);
    assign wr_ok = ok && bus_write;
    assign idx   = bus_addr[ADDR_W-1:2];

    for (genvar w = 0; w < NWORDS; w++) begin : g_we
        assign we[w] = wr_ok && (idx == IDX_W'(w)) && !is_din(w);
    end

    gpio_regfile u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .wdata (bus_wdata),
        .regs  (regs)
    );

    gpio_sclk_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .wr_dout   (we[D_OUT]),
        .prev_sclk (regs[D_OUT][SCLK_BIT]),
        .wdata     (bus_wdata),
        .evt       (evt)
    );

    gpio_readmux u_rd (
        .clk         (clk),
        .rst         (rst),
        .rd_req      (bus_valid && !bus_write),
        .ok          (ok),
        .idx         (idx),
        .regs        (regs),
        .flash_ready (flash_ready),
        .sensor_miso (sensor_miso),
        .rdata       (bus_rdata),
        .rvalid      (bus_rvalid)
    );

    assign flash_ale = regs[A_OUT][ALE_BIT];
    assign flash_cle = regs[A_OUT][CLE_BIT];
    assign flash_ce  = regs[A_OUT][CE_BIT];
    assign sclk_evt  = evt.pulse;
    assign sclk_rise = evt.rise;
    assign sclk_dat  = evt.dat;

    a_r5_strobes: assert property (@(posedge clk) disable iff (rst)
        we[A_OUT] |=> (flash_ale == $past(bus_wdata[ALE_BIT])) &&
                      (flash_cle == $past(bus_wdata[CLE_BIT])) &&
                      (flash_ce  == $past(bus_wdata[CE_BIT])));
    a_r7_level: assert property (@(posedge clk) disable iff (rst)
        sclk_evt |-> sclk_rise == regs[D_OUT][SCLK_BIT]);
    a_r10_size: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_size != SZ_WORD) |-> (we == '0));
endmodule

// File: tb/test_gpio_pin_regs.sv
module test_gpio_pin_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        flash_ready = 1'b0, sensor_miso = 1'b0;
    logic        flash_ale, flash_cle, flash_ce;
    logic        sclk_evt, sclk_rise, sclk_dat;

    int total = 0, bad = 0;
    bit done = 0;
    logic [31:0] sh [0:22];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_pin_regs i_gpio_pin_regs (.*);

    task automatic chk(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input int a, input logic [1:0] sz);
        int i;
        if (sz != 2'd2 || a >= 92) return 32'h0;
        i = a / 4;
        if (i == 1)  return (sh[0] & sh[2]) | (32'(flash_ready) << 7);
        if (i == 17) return (sh[16] & sh[18]) | (32'(sensor_miso) << 4);
        return sh[i];
    endfunction

    // drive at negedge, return at next negedge with the write's effect visible
    task automatic wr(input int a, input logic [31:0] d, input logic [1:0] sz);
        bit acc;
        bit exp_p;
        int i;
        acc = (sz == 2'd2) && (a < 92) && ((a/4) != 1) && ((a/4) != 17);
        i = a / 4;
        exp_p = acc && (i == 16) && (d[1] != sh[16][1]);
        bus_valid = 1; bus_write = 1; bus_addr = 7'(a); bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
        if (acc) sh[i] = d;
        chk(sclk_evt == exp_p, "R6 event presence", 32'(sclk_evt), 32'(exp_p));
        if (exp_p)
            chk(sclk_rise == d[1] && sclk_dat == d[4], "R7 event fields",
                {30'd0, sclk_rise, sclk_dat}, {30'd0, d[1], d[4]});
        chk({flash_ale, flash_cle, flash_ce} == {sh[0][6], sh[0][5], sh[0][4]}, "R5 flash strobes",
            32'({flash_ale, flash_cle, flash_ce}), 32'({sh[0][6], sh[0][5], sh[0][4]}));
    endtask

    task automatic rd(input int a, input logic [1:0] sz, input string req);
        logic [31:0] e;
        e = exp_rd(a, sz);
        bus_valid = 1; bus_write = 0; bus_addr = 7'(a); bus_size = sz;
        @(negedge clk);
        bus_valid = 0;
        chk(bus_rvalid == 1'b1, "R11 rvalid", 32'(bus_rvalid), 32'd1);
        chk(bus_rdata == e, req, bus_rdata, e);
    endtask

    function automatic string tag_of(input int a);
        if (a >= 92) return "R9 out of window";
        if (a/4 == 1) return "R3 port A view";
        if (a/4 == 17) return "R4 port D view";
        return "R2 readback";
    endfunction

    initial begin
        for (int i = 0; i < 23; i++) sh[i] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        chk(!sclk_evt && !flash_ale && !flash_cle && !flash_ce, "R1 reset outputs",
            {28'd0, sclk_evt, flash_ale, flash_cle, flash_ce}, 32'd0);
        for (int a = 0; a < 128; a += 4) rd(a, 2'd2, "R1 reset read");

        // sweep writes over the whole address space, including input views (R8) and beyond (R9)
        for (int a = 0; a < 128; a += 4)
            wr(a, 32'h5A00_0000 ^ (32'(a) * 32'h0101_0303), 2'd2);
        for (int m = 0; m < 4; m++) begin
            flash_ready = m[0]; sensor_miso = m[1];
            for (int a = 0; a < 128; a += 4) rd(a, 2'd2, tag_of(a));
        end
        // R8: input-view writes ignored, confirmed through both views
        wr(4, 32'hFFFF_FFFF, 2'd2);
        wr(68, 32'hFFFF_FFFF, 2'd2);
        rd(4, 2'd2, "R8 A view unchanged");
        rd(68, 2'd2, "R8 D view unchanged");

        // R10: non-word sizes
        for (int s = 0; s < 4; s++) begin
            if (s == 2) continue;
            wr(8, 32'h1234_5678, 2'(s));
            wr(64, ~sh[16], 2'(s));
            rd(8, 2'(s), "R10 bad size read");
            rd(8, 2'd2, "R10 bad size write ignored");
        end

        // R5: flash strobe patterns
        for (int p = 0; p < 8; p++) wr(0, 32'(p) << 4, 2'd2);

        // R6/R7: all combinations of prior level, new level and data
        for (int p = 0; p < 16; p++) wr(64, {27'd0, p[3], 2'b00, p[p%2], 1'b0}, 2'd2);
        for (int p = 0; p < 4; p++) begin
            wr(64, {27'd0, p[1], 2'b00, 1'b0, 1'b0}, 2'd2);
            wr(64, {27'd0, p[0], 2'b00, p[0], 1'b0}, 2'd2);
            wr(64, {27'd0, p[0], 2'b00, p[0], 1'b0}, 2'd2);
        end
        // back-to-back toggles: one edge per write
        wr(64, 32'h0, 2'd2);
        wr(64, 32'h2, 2'd2);
        wr(64, 32'h0, 2'd2);
        wr(64, 32'h12, 2'd2);

        // same-cycle: event visible while sensor answers and D view is read
        wr(72, 32'hFFFF_FFFF, 2'd2);
        sensor_miso = 0;
        wr(64, 32'h0000_0100, 2'd2);
        wr(64, 32'h0000_0102, 2'd2);
        chk(sclk_evt == 1'b1, "R7 event before merged read", 32'(sclk_evt), 32'd1);
        sensor_miso = 1;
        rd(68, 2'd2, "R4 merged read at event");
        chk(sclk_evt == 1'b0, "R7 single-cycle pulse", 32'(sclk_evt), 32'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule